// File: doc/BRIEF.md
# Boot Configuration Source Selector

After power-on reset this block decides which configuration map the chip uses. It counts millisecond ticks through a short internal initialisation window and then a longer settling window. When the second window has passed, it reads two signature bytes from an external serial EEPROM through a byte-read request/acknowledge handshake with an I2C master that sits outside the block. If both bytes match and every read completes cleanly, the whole EEPROM map is copied into a local register file. Otherwise the block samples two strap pins and selects one of four built-in maps.

Once the choice is made it is frozen until the next reset. The chosen map is exposed through a combinational byte read port. The block also decodes two fields of map byte 2 for the audio sample-redistribution logic. A USB connect-enable output stays low until configuration is complete, so the host never sees the device before its descriptors are settled.

Top module: `cfg_boot_select`

## Requirements
- R1: While reset is asserted and directly after it, `rd_req`, `init_done`, `cfg_done`, `usb_connect_en` and `cfg_rd_data` are all 0.
- R2: `init_done` rises on the clock edge that registers the INIT_MS-th `ms_tick` (default 10). `rd_req` stays low until ACCESS_MS ticks (default 120) have been registered, and it rises one clock edge after the edge that registers the ACCESS_MS-th tick.
- R3: The EEPROM is accepted only if address 0 returns 0xAA and address 1 returns 0x55. The first mismatching byte ends all reading: no further request follows it.
- R4: Reads go strictly in ascending address order from 0 to MAP_BYTES-1, with one outstanding at a time. `rd_req` is held with a stable `rd_addr` until a cycle in which `rd_ack` is high, which completes that address. The next address is one higher.
- R5: When the signature matches and all MAP_BYTES reads complete without error, `cfg_from_eeprom` is 1, `cfg_map_sel` is 0, and `cfg_rd_data` at address a equals the byte the EEPROM returned for a.
- R6: A completed read with `rd_err` high is treated as an absent EEPROM. The block falls back to the strap map and issues no further request.
- R7: On fallback, `cfg_map_sel` = {`strap_hi`,`strap_lo`} as sampled in the deciding cycle, and `cfg_rd_data` at address a equals (37*a + 101*sel + 19) mod 256.
- R8: After `cfg_done` is set, strap changes have no effect: `cfg_map_sel`, `cfg_from_eeprom` and the map contents stay fixed until reset.
- R9: Bits [1:0] of map byte 2 drive `asr_mode`: 0 means stop, 1 means 8-bit, 2 means 16-bit, 3 means 20-bit LSB-justified. Bits [3:2] select `pll_lock_len`: code 0 gives 512, 1 gives 2048, 2 gives 4096 and 3 gives 16384 samples.
- R10: `usb_connect_en` equals `cfg_done`.
- R11: Before `cfg_done`, `cfg_rd_data`, `asr_mode` and `pll_lock_len` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| strap_hi | input | 1 | Strap pin, upper select bit |
| strap_lo | input | 1 | Strap pin, lower select bit |
| rd_req | output | 1 | EEPROM byte read request |
| rd_addr | output | AW | Address of the requested byte |
| rd_ack | input | 1 | Read complete; data and error valid this cycle |
| rd_data | input | 8 | Byte returned by the read |
| rd_err | input | 1 | Read failed (no acknowledge or bus error) |
| cfg_rd_addr | input | AW | Map byte address for the rest of the chip |
| cfg_rd_data | output | 8 | Map byte at `cfg_rd_addr` |
| init_done | output | 1 | Initialisation window elapsed |
| cfg_done | output | 1 | Map chosen and frozen |
| cfg_from_eeprom | output | 1 | Map came from the EEPROM |
| cfg_map_sel | output | 2 | Built-in map index on fallback |
| asr_mode | output | 2 | Redistributor start-up mode |
| pll_lock_len | output | 15 | PLL lock length in samples |
| usb_connect_en | output | 1 | USB attach permitted |

## Verification
The hardest situation to reach is an error on the very last byte of an otherwise valid map. At that point the whole register file already holds EEPROM data, yet the block must still fall back and present the strap map. The bench's EEPROM model accepts a per-run error address, so this case is driven directly, alongside errors at the start and in the middle of a stream. A scoreboard queue filled with the expected address sequence is popped by the responder on every new request, which catches any reordering, skipped address or request issued after the decision.

// File: rtl/cfg_boot_pkg.sv
package cfg_boot_pkg;

  typedef enum logic [2:0] {
    ST_HOLD, ST_SIG0, ST_SIG1, ST_BODY, ST_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    ASR_STOP, ASR_LSB8, ASR_LSB16, ASR_LSB20
  } asr_mode_t;

  localparam logic [7:0] SIG_FIRST  = 8'hAA;
  localparam logic [7:0] SIG_SECOND = 8'h55;
  localparam int         CTL_BYTE   = 2;

  // Built-in map contents: a computed pattern per strap selection.
  function automatic logic [7:0] builtin_byte(input logic [1:0] sel,
                                              input logic [15:0] addr);
    logic [15:0] acc;
    acc = addr * 16'd37 + {14'd0, sel} * 16'd101 + 16'd19;
    return acc[7:0];
  endfunction

  // PLL lock length in samples for a 2-bit code.
  function automatic logic [14:0] lock_len(input logic [1:0] code);
    case (code)
      2'd0:    return 15'd512;
      2'd1:    return 15'd2048;
      2'd2:    return 15'd4096;
      default: return 15'd16384;
    endcase
  endfunction

endpackage

// File: rtl/cfg_boot_timer.sv
module cfg_boot_timer #(
  parameter int INIT_MS   = 10,
  parameter int ACCESS_MS = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  output logic init_done,
  output logic access_open
);
  localparam int CW = $clog2(ACCESS_MS + 1);
  localparam logic [CW-1:0] INIT_LIM = CW'(INIT_MS);
  localparam logic [CW-1:0] ACC_LIM  = CW'(ACCESS_MS);

  logic [CW-1:0] ms_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ms_cnt <= '0;
    else if (ms_tick && ms_cnt != ACC_LIM) ms_cnt <= ms_cnt + 1'b1;
  end

  assign init_done   = (ms_cnt >= INIT_LIM);
  assign access_open = (ms_cnt == ACC_LIM);

  a_r2_init_before_access: assert property (@(posedge clk) disable iff (!rst_n)
    access_open |-> init_done);
endmodule

// File: rtl/cfg_boot_seq.sv
module cfg_boot_seq
  import cfg_boot_pkg::*;
#(
  parameter int MAP_BYTES = 128,
  parameter int AW        = $clog2(MAP_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          access_open,
  input  logic [1:0]    strap,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [7:0]    rd_data,
  input  logic          rd_err,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          cfg_done,
  output logic          from_eeprom,
  output logic [1:0]    map_sel
);
  localparam logic [AW-1:0] LAST = AW'(MAP_BYTES - 1);

  seq_state_t    state;
  logic [AW-1:0] addr;
  logic          reading, sig_bad, xfer_bad, at_last;

  assign reading  = (state == ST_SIG0) || (state == ST_SIG1) || (state == ST_BODY);
  assign sig_bad  = ((state == ST_SIG0) && (rd_data != SIG_FIRST)) ||
                    ((state == ST_SIG1) && (rd_data != SIG_SECOND));
  assign xfer_bad = rd_ack && (rd_err || sig_bad);
  assign at_last  = (addr == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_HOLD;
      addr        <= '0;
      from_eeprom <= 1'b0;
      map_sel     <= 2'd0;
    end else begin
      case (state)
        ST_HOLD: if (access_open) state <= ST_SIG0;
        ST_SIG0, ST_SIG1, ST_BODY: begin
          if (rd_ack) begin
            if (xfer_bad) begin
              map_sel <= strap;
              state   <= ST_DONE;
            end else if (at_last) begin
              from_eeprom <= 1'b1;
              state       <= ST_DONE;
            end else begin
              addr  <= addr + 1'b1;
              state <= (state == ST_SIG0) ? ST_SIG1 : ST_BODY;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign rd_req   = reading;
  assign rd_addr  = addr;
  assign wr_en    = reading && rd_ack && !xfer_bad;
  assign wr_addr  = addr;
  assign wr_data  = rd_data;
  assign cfg_done = (state == ST_DONE);

  a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_ack) |=> (!rd_req || rd_addr == AW'($past(rd_addr) + 1'b1)));
  a_r6_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> !rd_req);
  a_r8_locked: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> (cfg_done && $stable(map_sel) && $stable(from_eeprom)));
endmodule

// File: rtl/cfg_map_store.sv
module cfg_map_store
  import cfg_boot_pkg::*;
#(
  parameter int MAP_BYTES = 128,
  parameter int AW        = $clog2(MAP_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          done,
  input  logic          from_eeprom,
  input  logic [1:0]    map_sel,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic [7:0]    ctl_byte
);
  logic [7:0] mem [MAP_BYTES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  function automatic logic [7:0] pick(input logic [AW-1:0] a);
    if (!done || int'(a) >= MAP_BYTES) return 8'd0;
    if (from_eeprom)                    return mem[a];
    return builtin_byte(map_sel, 16'(a));
  endfunction

  assign rd_data  = pick(rd_addr);
  assign ctl_byte = pick(AW'(CTL_BYTE));

  a_r8_no_write_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !done);
endmodule

// File: rtl/cfg_boot_select.sv
module cfg_boot_select
  import cfg_boot_pkg::*;
#(
  parameter int MAP_BYTES = 128,
  parameter int INIT_MS   = 10,
  parameter int ACCESS_MS = 120,
  localparam int AW       = $clog2(MAP_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ms_tick,
  input  logic          strap_hi,
  input  logic          strap_lo,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [7:0]    rd_data,
  input  logic          rd_err,
  input  logic [AW-1:0] cfg_rd_addr,
  output logic [7:0]    cfg_rd_data,
  output logic          init_done,
  output logic          cfg_done,
  output logic          cfg_from_eeprom,
  output logic [1:0]    cfg_map_sel,
  output logic [1:0]    asr_mode,
  output logic [14:0]   pll_lock_len,
  output logic          usb_connect_en
);
  logic          access_open;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic [7:0]    ctl_byte;

  cfg_boot_timer #(.INIT_MS(INIT_MS), .ACCESS_MS(ACCESS_MS)) u_timer (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
    .init_done(init_done), .access_open(access_open)
  );

  cfg_boot_seq #(.MAP_BYTES(MAP_BYTES), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .access_open(access_open),
    .strap({strap_hi, strap_lo}),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
    .rd_data(rd_data), .rd_err(rd_err),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_done(cfg_done), .from_eeprom(cfg_from_eeprom), .map_sel(cfg_map_sel)
  );

  cfg_map_store #(.MAP_BYTES(MAP_BYTES), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(cfg_done), .from_eeprom(cfg_from_eeprom), .map_sel(cfg_map_sel),
    .rd_addr(cfg_rd_addr), .rd_data(cfg_rd_data), .ctl_byte(ctl_byte)
  );

  assign asr_mode       = ctl_byte[1:0];
  assign pll_lock_len   = cfg_done ? lock_len(ctl_byte[3:2]) : 15'd0;
  assign usb_connect_en = cfg_done;

  a_r2_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> access_open);
  a_r10_connect_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(usb_connect_en) |-> $past(rd_req));
endmodule

// File: tb/cfg_boot_select_test.sv
module cfg_boot_select_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAP   = 128;
  localparam int AW    = $clog2(MAP);
  localparam int INIT  = 10;
  localparam int ACC   = 120;
  localparam int LAT   = 2;
  localparam int TDIV  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0;
  logic strap_hi = 1'b0, strap_lo = 1'b0;
  logic rd_req, rd_ack = 1'b0, rd_err = 1'b0;
  logic [AW-1:0] rd_addr, cfg_rd_addr = '0;
  logic [7:0] rd_data = '0, cfg_rd_data;
  logic init_done, cfg_done, cfg_from_eeprom, usb_connect_en;
  logic [1:0] cfg_map_sel, asr_mode;
  logic [14:0] pll_lock_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_boot_select #(.MAP_BYTES(MAP), .INIT_MS(INIT), .ACCESS_MS(ACC)) uut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .strap_hi(strap_hi), .strap_lo(strap_lo),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data), .rd_err(rd_err),
    .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data), .init_done(init_done),
    .cfg_done(cfg_done), .cfg_from_eeprom(cfg_from_eeprom), .cfg_map_sel(cfg_map_sel),
    .asr_mode(asr_mode), .pll_lock_len(pll_lock_len), .usb_connect_en(usb_connect_en)
  );

  int vectors = 0, errors = 0;
  logic [7:0] ee [MAP];
  int err_at = -1;
  int exp_q[$];
  int req_seen = 0;
  int ticks_sent = 0;
  bit tick_en = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // millisecond tick source
  always @(negedge clk) begin : tick_gen
    static int div = 0;
    ms_tick <= 1'b0;
    if (!tick_en) div = 0;
    else begin
      div++;
      if (div == TDIV) begin
        div = 0;
        ms_tick <= 1'b1;
        ticks_sent++;
      end
    end
  end

  // EEPROM responder and address scoreboard (R4)
  always @(negedge clk) begin : responder
    static bit busy = 1'b0;
    static int cnt = 0;
    static int cur = 0;
    if (rd_ack) begin
      rd_ack <= 1'b0;
      rd_err <= 1'b0;
      busy = 1'b0;
    end else if (busy) begin
      cnt--;
      if (cnt == 0) begin
        rd_ack  <= 1'b1;
        rd_data <= ee[cur];
        rd_err  <= (cur == err_at);
      end
    end
    if (!busy && !rd_ack && rst_n && rd_req) begin
      busy = 1'b1;
      cnt  = LAT;
      cur  = int'(rd_addr);
      req_seen++;
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected request", cur, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(cur == e, "R4 read address order", cur, e);
      end
    end
  end

  function automatic int bi_byte(int s, int a);
    return (a * 37 + s * 101 + 19) % 256;
  endfunction

  function automatic int lock_exp(int code);
    return 512 << ((code == 0) ? 0 : (code == 1) ? 2 : (code == 2) ? 3 : 5);
  endfunction

  task automatic run_case(input int s0, input int s1, input int eat, input int strap,
                          input bit exp_ee, input int nreq, input bit timing);
    int bad, got, ctl;
    rst_n = 1'b0; tick_en = 1'b0; ticks_sent = 0; req_seen = 0;
    exp_q.delete();
    err_at = eat;
    {strap_hi, strap_lo} = 2'(strap);
    for (int a = 0; a < MAP; a++) ee[a] = 8'((a * 29 + 11) % 256);
    ee[0] = 8'(s0); ee[1] = 8'(s1); ee[2] = 8'h0E;
    cfg_rd_addr = AW'(5);
    repeat (3) @(negedge clk);
    chk(!rd_req && !init_done && !cfg_done && !usb_connect_en && cfg_rd_data == 0,
        "R1 reset outputs", {rd_req, init_done, cfg_done, usb_connect_en}, 0);
    chk(cfg_rd_data == 0 && pll_lock_len == 0, "R11 quiet before done", cfg_rd_data, 0);
    for (int a = 0; a < nreq; a++) exp_q.push_back(a);
    rst_n = 1'b1;
    tick_en = 1'b1;
    if (timing) begin
      wait (ticks_sent == INIT);
      chk(init_done == 1'b0, "R2 init not yet", init_done, 0);
      @(negedge clk);
      chk(init_done == 1'b1, "R2 init after ticks", init_done, 1);
      wait (ticks_sent == ACC);
      chk(rd_req == 1'b0, "R2 no early request", rd_req, 0);
      @(negedge clk);
      chk(rd_req == 1'b0, "R2 request one edge later", rd_req, 0);
      @(negedge clk);
      chk(rd_req == 1'b1 && rd_addr == 0, "R2 first request", rd_req, 1);
    end
    for (int c = 0; c < 5000 && !cfg_done; c++) @(negedge clk);
    chk(cfg_done == 1'b1, "watchdog cfg_done", cfg_done, 1);
    chk(usb_connect_en == 1'b1, "R10 connect after done", usb_connect_en, 1);
    repeat (6) @(negedge clk);
    chk(req_seen == nreq && exp_q.size() == 0, "R3/R6 request count", req_seen, nreq);
    chk(cfg_from_eeprom == exp_ee, "R5/R6 source", cfg_from_eeprom, exp_ee);
    chk(cfg_map_sel == (exp_ee ? 0 : strap), "R7 map select", cfg_map_sel, exp_ee ? 0 : strap);
    bad = 0; got = 0;
    for (int a = 0; a < MAP; a++) begin
      int e;
      cfg_rd_addr = AW'(a);
      #1;
      e = exp_ee ? int'(ee[a]) : bi_byte(strap, a);
      if (int'(cfg_rd_data) != e) begin bad++; got = cfg_rd_data; end
    end
    chk(bad == 0, exp_ee ? "R5 eeprom map contents" : "R7 builtin map contents", got, bad);
    ctl = exp_ee ? 8'h0E : bi_byte(strap, 2);
    chk(asr_mode == 2'(ctl & 3), "R9 asr mode", asr_mode, ctl & 3);
    chk(int'(pll_lock_len) == lock_exp((ctl >> 2) & 3), "R9 pll lock length",
        pll_lock_len, lock_exp((ctl >> 2) & 3));
  endtask

  initial begin
    run_case(8'hAA, 8'h55, -1, 0, 1'b1, MAP, 1'b1);   // R5 full load
    run_case(8'h12, 8'h55, -1, 2, 1'b0, 1, 1'b0);     // R3 first byte bad
    begin : lock_check   // R8 straps ignored after done
      logic [1:0] sel0;
      logic [7:0] b0;
      sel0 = cfg_map_sel;
      cfg_rd_addr = AW'(9); #1; b0 = cfg_rd_data;
      {strap_hi, strap_lo} = ~{strap_hi, strap_lo};
      repeat (20) @(negedge clk);
      cfg_rd_addr = AW'(9); #1;
      chk(cfg_map_sel == sel0 && cfg_rd_data == b0 && cfg_done, "R8 frozen selection",
          cfg_map_sel, sel0);
    end
    run_case(8'hAA, 8'h54, -1, 1, 1'b0, 2, 1'b0);     // R3 second byte bad
    run_case(8'hAA, 8'h55, 1, 3, 1'b0, 2, 1'b0);      // R6 error on signature
    run_case(8'hAA, 8'h55, 50, 0, 1'b0, 51, 1'b0);    // R6 error mid stream
    run_case(8'hAA, 8'h55, MAP-1, 2, 1'b0, MAP, 1'b0); // R6 error on last byte
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule